// File: doc/BRIEF.md
# Break-Before-Make One-Hot Switch Selector

This block steers a bank of external switches, each of which ties one fixed reference level to a shared output node. A code word of `CODE_W` bits is captured on a load strobe and decoded into exactly one of `2**CODE_W` registered enable lines. The code-to-level table lives outside the block, in the wiring of the switches.

Closing two switches at once would short two references together. The block therefore never moves an enable straight from one line to another. On a new code the active line drops at once. Every line then stays low for `DEAD` clock cycles, and only after that gap does the newly selected line rise. All enables come from flip-flops, so skew between input bits never reaches the switches as a transient code. An elaboration-time option reads the code as reflected Gray, which is a unit-distance code, and converts it to binary before the decoder.

`busy` is high while a change is in progress. Loads that arrive during the gap do not stretch it: the last code loaded before the gap ends is the one that gets switched in. Reloading the code that is already active has no effect.

Top module: `bbm_switch_select`

## Requirements
- R1: While `rst` is high, all enables are low and `busy` is high. After `rst` is released, the enable of `RESET_CODE` rises on the `DEAD`-th rising clock edge, and `busy` falls on that same edge.
- R2: When `load` is sampled high in the idle state with a code that differs from the active one, all enables go low and `busy` goes high on that same clock edge.
- R3: After the edge of R2, all enables stay low for exactly `DEAD` cycles. On the `DEAD`-th following edge, only enable bit `k` goes high, where `k` is the binary value of the loaded code, and `busy` goes low on that edge.
- R4: At most one enable is high in any cycle.
- R5: Between two different enables there is always at least one cycle with all enables low. Enable `i` is never followed directly by enable `j` with `j != i`.
- R6: Loading the code that is already active leaves the enables unchanged and keeps `busy` low.
- R7: A load during the gap does not extend the gap. The code of the latest such load is the one enabled when the gap ends.
- R8: While `load` is low, changes on `code_in` do not affect the enables or `busy`.
- R9: With `GRAY_IN = 1`, `code_in` is read as reflected Gray code. Bit `k` of the enables is selected, where `k` is the Gray-to-binary value (`b[msb] = g[msb]`, `b[i] = b[i+1] ^ g[i]`).
- R10: Whenever `busy` is high, all enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for `code_in` |
| code_in | input | CODE_W | Selection code, binary or Gray depending on `GRAY_IN` |
| sw_en | output | 2**CODE_W | Registered one-hot switch enables |
| busy | output | 1 | High from the accepted load until the new enable is up |

## Verification
The assertions assume that `load` and `code_in` are synchronous to `clk` and stable around its rising edge. They also assume that `rst` is held for at least one edge before any checked cycle, so that the past values they compare are defined. The bench drives every input on the falling edge and holds reset for several cycles. Random traffic only loads new codes while `busy` is low. Loads during the gap are produced only by directed sequences, and the bench knows the expected result of each of those sequences.

// File: rtl/bbm_sel_pkg.sv
package bbm_sel_pkg;

    typedef enum logic {
        PH_GAP = 1'b0,
        PH_ON  = 1'b1
    } phase_e;

    localparam int MAX_CODE_W = 16;

    function automatic logic [MAX_CODE_W-1:0] gray_to_bin(input logic [MAX_CODE_W-1:0] g);
        logic [MAX_CODE_W-1:0] b;
        b[MAX_CODE_W-1] = g[MAX_CODE_W-1];
        for (int i = MAX_CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/bbm_code_conv.sv
module bbm_code_conv
    import bbm_sel_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter bit GRAY_IN = 1'b0
) (
    input  logic [CODE_W-1:0] raw_i,
    output logic [CODE_W-1:0] bin_o
);

    generate
        if (GRAY_IN) begin : g_gray
            logic [MAX_CODE_W-1:0] wide;
            assign wide  = gray_to_bin(MAX_CODE_W'(raw_i));
            assign bin_o = wide[CODE_W-1:0];
        end else begin : g_bin
            assign bin_o = raw_i;
        end
    endgenerate

endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
    import bbm_sel_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int DEAD       = 2,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              live_d,
    output logic [CODE_W-1:0] code_d,
    output logic              busy_o
);

    localparam int CNT_W = (DEAD > 1) ? $clog2(DEAD) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEAD - 1);

    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CODE_W-1:0] tgt_q, tgt_d;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        tgt_d   = tgt_q;
        live_d  = 1'b0;
        if (phase_q == PH_ON) begin
            if (load && code != tgt_q) begin
                phase_d = PH_GAP;
                cnt_d   = CNT_TOP;
                tgt_d   = code;
            end else begin
                live_d = 1'b1;
            end
        end else begin
            if (load) begin
                tgt_d = code;
            end
            if (cnt_q == '0) begin
                phase_d = PH_ON;
                live_d  = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    assign code_d = tgt_d;
    assign busy_o = (phase_q == PH_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_GAP;
            cnt_q   <= CNT_TOP;
            tgt_q   <= CODE_W'(RESET_CODE);
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            tgt_q   <= tgt_d;
        end
    end

    // R6
    same_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ON && load && code == tgt_q) |=> (phase_q == PH_ON && tgt_q == $past(tgt_q)));

    // R2
    new_code_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ON && load && code != tgt_q) |=> (phase_q == PH_GAP && tgt_q == $past(code)));

    // R7
    gap_latest_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GAP && load) |=> (tgt_q == $past(code)));

    // R3
    gap_count_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_GAP && cnt_q != '0) |=> (phase_q == PH_GAP && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bbm_drive.sv
module bbm_drive #(
    parameter int CODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  live_d,
    input  logic [CODE_W-1:0]     code_d,
    output logic [2**CODE_W-1:0]  en_o
);

    localparam int LINES = 2 ** CODE_W;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_o[i] <= 1'b0;
                end else begin
                    en_o[i] <= live_d && (code_d == CODE_W'(i));
                end
            end
        end
    endgenerate

    // R4
    single_hot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en_o));

    // R5
    break_first_chk: assert property (@(posedge clk) disable iff (rst)
        (en_o != '0 && $past(en_o) != '0) |-> (en_o == $past(en_o)));

endmodule

// File: rtl/bbm_switch_select.sv
module bbm_switch_select #(
    parameter int CODE_W     = 3,
    parameter int DEAD       = 2,
    parameter int RESET_CODE = 0,
    parameter bit GRAY_IN    = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [CODE_W-1:0]    code_in,
    output logic [2**CODE_W-1:0] sw_en,
    output logic                 busy
);

    logic [CODE_W-1:0] bin_code;
    logic              live_d;
    logic [CODE_W-1:0] code_d;

    bbm_code_conv #(.CODE_W(CODE_W), .GRAY_IN(GRAY_IN)) u_conv (
        .raw_i (code_in),
        .bin_o (bin_code)
    );

    bbm_seq #(.CODE_W(CODE_W), .DEAD(DEAD), .RESET_CODE(RESET_CODE)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .code   (bin_code),
        .live_d (live_d),
        .code_d (code_d),
        .busy_o (busy)
    );

    bbm_drive #(.CODE_W(CODE_W)) u_drive (
        .clk    (clk),
        .rst    (rst),
        .live_d (live_d),
        .code_d (code_d),
        .en_o   (sw_en)
    );

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sw_en == '0));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (sw_en == '0 && busy));

endmodule

// File: tb/bbm_switch_select_test.sv
`timescale 1ns/1ps
module bbm_switch_select_test;

    localparam int CW     = 3;
    localparam int NL     = 2 ** CW;
    localparam int DEAD   = 2;
    localparam int DEAD_G = 3;
    localparam int RCODE  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic [CW-1:0] code_in = '0;
    logic [NL-1:0] sw_en;
    logic busy;

    logic gload = 1'b0;
    logic [CW-1:0] gcode = '0;
    logic [NL-1:0] gsw_en;
    logic gbusy;

    int n_chk = 0;
    int n_fail = 0;
    int cur = RCODE;
    int unsigned seed = 32'd20240611;

    always #5 clk = ~clk;

    bbm_switch_select #(.CODE_W(CW), .DEAD(DEAD), .RESET_CODE(RCODE), .GRAY_IN(1'b0)) uut (
        .clk(clk), .rst(rst), .load(load), .code_in(code_in), .sw_en(sw_en), .busy(busy));

    bbm_switch_select #(.CODE_W(CW), .DEAD(DEAD_G), .RESET_CODE(0), .GRAY_IN(1'b1)) uut_gray (
        .clk(clk), .rst(rst), .load(gload), .code_in(gcode), .sw_en(gsw_en), .busy(gbusy));

    function automatic logic [NL-1:0] hot(input int idx);
        return NL'(1) << idx;
    endfunction

    function automatic int gray_val(input int g);
        int b = 0;
        for (int s = g; s != 0; s = s >> 1) b = b ^ s;
        return b;
    endfunction

    task automatic check(input string req, input logic [NL-1:0] en_act, input logic [NL-1:0] en_exp,
                         input logic b_act, input logic b_exp);
        n_chk++;
        if (en_act !== en_exp || b_act !== b_exp) begin
            n_fail++;
            $display("FAIL %s: en=%b busy=%b expected en=%b busy=%b", req, en_act, b_act, en_exp, b_exp);
        end
    endtask

    task automatic switch_to(input int c, input string req);
        load = 1'b1; code_in = CW'(c);
        @(negedge clk);
        load = 1'b0;
        if (c == cur) begin
            check({req, "/R6 reload"}, sw_en, hot(cur), busy, 1'b0);
        end else begin
            check({req, "/R2 drop"}, sw_en, '0, busy, 1'b1);
            for (int k = 2; k <= DEAD; k++) begin
                @(negedge clk);
                check({req, "/R3 gap"}, sw_en, '0, busy, 1'b1);
            end
            @(negedge clk);
            check({req, "/R3 rise"}, sw_en, hot(c), busy, 1'b0);
            cur = c;
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 in reset", sw_en, '0, busy, 1'b1);
        rst = 1'b0;
        for (int k = 1; k < DEAD; k++) begin
            @(negedge clk);
            check("R1 post-reset gap", sw_en, '0, busy, 1'b1);
        end
        @(negedge clk);
        check("R1 reset code up", sw_en, hot(RCODE), busy, 1'b0);

        switch_to(2, "R3 basic");
        switch_to(2, "R6 same");
        switch_to(7, "R3 top");
        switch_to(0, "R3 bottom");

        // R8: code changes without load
        for (int k = 0; k < 4; k++) begin
            code_in = CW'(k + 3);
            @(negedge clk);
            check("R8 no load", sw_en, hot(cur), busy, 1'b0);
        end

        // R7: second load during gap replaces target, gap not extended
        load = 1'b1; code_in = 3'd4;
        @(negedge clk);
        check("R7 drop", sw_en, '0, busy, 1'b1);
        code_in = 3'd6;
        @(negedge clk);
        load = 1'b0;
        check("R7 gap", sw_en, '0, busy, 1'b1);
        @(negedge clk);
        check("R7 latest", sw_en, hot(6), busy, 1'b0);
        cur = 6;

        // R7: gap load back to the old code still completes the gap
        load = 1'b1; code_in = 3'd1;
        @(negedge clk);
        code_in = 3'd6;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        check("R7 back to old", sw_en, hot(6), busy, 1'b0);

        // R4 R5: random traffic
        for (int it = 0; it < 60; it++) begin
            int c;
            c = int'($urandom(seed) % NL);
            seed = seed + 32'd7919;
            switch_to(c, "R4 R5 random");
            repeat (int'($urandom(seed) % 3)) begin
                @(negedge clk);
                check("R4 idle hold", sw_en, hot(cur), busy, 1'b0);
            end
        end

        // R9: Gray input instance, enable index from Gray-to-binary
        for (int g = 1; g < NL; g++) begin
            gload = 1'b1; gcode = CW'(g);
            @(negedge clk);
            gload = 1'b0;
            check("R9 gray drop", gsw_en, '0, gbusy, 1'b1);
            for (int k = 2; k <= DEAD_G; k++) @(negedge clk);
            check("R9 gray gap", gsw_en, '0, gbusy, 1'b1);
            @(negedge clk);
            check("R9 gray up", gsw_en, hot(gray_val(g)), gbusy, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule